// File: doc/BRIEF.md
# Disk Controller Command Intake Handshake

This block is the host-facing front end of a floppy-style disk controller. The host writes a command opcode byte, then the exact number of parameter bytes that opcode needs, one at a time. Before each write the host polls a main status byte for a ready flag (RQM) and a direction flag (DIO). The block steps through three phases in a fixed sequence: command, execution and result. It drops RQM after every accepted byte and keeps it low for a fixed processing time. It raises RQM again for each further parameter byte. After the last parameter it keeps RQM low and starts the execution phase by itself.

Execution happens outside the block. The execution engine receives the opcode together with a one-cycle start pulse and each parameter byte as it arrives. It pushes any result bytes into a small internal queue and then signals that it is done. The host reads the result bytes back in the result phase, with DIO high. After the last result byte has been read, the block returns to the command phase. If the opcode is not recognised, execution is skipped and the block presents a single invalid-status byte as the result. The data FIFO enable stays off outside the execution phase.

The state machine has five states. CMD_IDLE waits for an opcode. CMD_PROC is the fixed processing window after any accepted byte. CMD_PARAM waits for the next parameter byte. EXEC waits for the execution engine. RESULT drains the result queue.

The transitions are:
- CMD_IDLE to CMD_PROC on an accepted opcode write.
- CMD_PARAM to CMD_PROC on an accepted parameter write.
- CMD_PROC to RESULT when the window ends and the opcode is invalid.
- CMD_PROC to EXEC when the window ends and all parameters have been received.
- CMD_PROC to CMD_PARAM when the window ends and more parameters are needed.
- EXEC to RESULT on done with the queue non-empty.
- EXEC to CMD_IDLE on done with the queue empty.
- RESULT to CMD_IDLE when the last queued byte is read.

Top module: `disk_cmd_intake`

## Requirements
- R1: After reset the status byte reads 0x80, with bit 7 = RQM = 1, bit 6 = DIO = 0 and bit 4 = busy = 0. In the same state fifo_en and exec_start are 0 and host_rdata is 0.
- R2: A host write is accepted only while RQM = 1 and DIO = 0. A write made while RQM = 0 has no effect: it produces no param_valid pulse, and it does not count as a parameter byte.
- R3: After every accepted write RQM reads 0 for exactly 2 clock cycles. If the opcode still needs parameter bytes, the status then reads 0x90 (RQM = 1, DIO = 0, busy = 1).
- R4: The parameter count is chosen by opcode bits [4:0]; bits [7:5] are modifier bits and are ignored. The counts are: 0x06 read 8, 0x05 write 8, 0x0F seek 2, 0x03 specify 2, 0x04 drive status 1, 0x07 recalibrate 1, 0x08 interrupt status 0. Every other code is invalid.
- R5: Each accepted parameter byte is reported for one cycle, in the cycle after the write edge. The report carries param_valid = 1, param_byte set to the written byte, and param_idx counting 0, 1, 2 and so on in arrival order.
- R6: Two cycles after the last parameter byte, or after the opcode for a 0-parameter command, exec_start pulses for exactly one cycle with exec_op equal to the full opcode. While execution is under way the status reads 0x10 (RQM = 0, busy = 1) and fifo_en is 1.
- R7: fifo_en is 0 in the command phase and in the result phase.
- R8: Two cycles after an invalid opcode the block enters the result phase without an exec_start pulse. It offers the single byte 0x80 with the status at 0xD0 (RQM = 1, DIO = 1). Reading that byte returns the block to status 0x80.
- R9: exec_done moves the block to the result phase. There RQM = DIO = 1 while a byte is queued, and host reads return the queued bytes in push order. Reading the last byte returns the status to 0x80. If no byte is queued when exec_done arrives, the status goes directly to 0x80.
- R10: res_push outside the execution phase is ignored, and so is host_rd outside the result phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host data-register write strobe, one cycle |
| host_rd | input | 1 | Host data-register read strobe, one cycle |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Head result byte; 0 outside the result phase |
| msr | output | 8 | Main status: bit 7 RQM, bit 6 DIO, bit 4 busy |
| fifo_en | output | 1 | Data FIFO enable, high only during execution |
| param_valid | output | 1 | One-cycle pulse for each accepted parameter byte |
| param_idx | output | 4 | Position of the reported parameter byte |
| param_byte | output | 8 | Value of the reported parameter byte |
| exec_start | output | 1 | One-cycle pulse starting execution |
| exec_op | output | 8 | Opcode of the current command |
| exec_done | input | 1 | Execution engine finished |
| res_push | input | 1 | Push res_byte into the result queue (execution phase only) |
| res_byte | input | 8 | Result byte to push |

## Verification
The checker assumes that host_wr and host_rd are single-cycle strobes and are never raised in the same cycle. It also assumes that the execution engine pushes no more bytes than the queue holds before it raises exec_done. The bench drives every strobe for exactly one clock from the falling edge and keeps each command to at most two pushed result bytes. It deliberately writes while RQM is low and pushes or reads in the wrong phase, to show that those strobes are dropped.

// File: rtl/disk_cmd_pkg.sv
package disk_cmd_pkg;

    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 4;
    localparam logic [BYTE_W-1:0] INVALID_STATUS = 8'h80;

    typedef enum logic [2:0] {
        ST_CMD_IDLE,
        ST_CMD_PROC,
        ST_CMD_PARAM,
        ST_EXEC,
        ST_RESULT
    } phase_t;

    typedef struct packed {
        logic             known;
        logic [IDX_W-1:0] nparams;
    } op_info_t;

    function automatic op_info_t lookup_op(input logic [4:0] code);
        op_info_t r;
        r.known   = 1'b1;
        r.nparams = '0;
        unique case (code)
            5'h06:   r.nparams = 4'd8;
            5'h05:   r.nparams = 4'd8;
            5'h0F:   r.nparams = 4'd2;
            5'h03:   r.nparams = 4'd2;
            5'h04:   r.nparams = 4'd1;
            5'h07:   r.nparams = 4'd1;
            5'h08:   r.nparams = 4'd0;
            default: r.known   = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmd_opcode_decode.sv
module cmd_opcode_decode
    import disk_cmd_pkg::*;
(
    input  logic [4:0]       code,
    output logic             known,
    output logic [IDX_W-1:0] nparams
);
    op_info_t info;

    always_comb begin
        info    = lookup_op(code);
        known   = info.known;
        nparams = info.nparams;
    end
endmodule

// File: rtl/cmd_proc_timer.sv
module cmd_proc_timer #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/cmd_result_queue.sv
module cmd_result_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         last
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] TOP  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign last    = (cnt == CW'(1));
    assign do_push = push && (cnt != FULL);
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == TOP) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == TOP) ? '0 : rptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/disk_cmd_intake.sv
module disk_cmd_intake
    import disk_cmd_pkg::*;
#(
    parameter int PROC_CYCLES = 2,
    parameter int RES_DEPTH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic [BYTE_W-1:0] msr,
    output logic              fifo_en,
    output logic              param_valid,
    output logic [IDX_W-1:0]  param_idx,
    output logic [BYTE_W-1:0] param_byte,
    output logic              exec_start,
    output logic [BYTE_W-1:0] exec_op,
    input  logic              exec_done,
    input  logic              res_push,
    input  logic [BYTE_W-1:0] res_byte
);
    phase_t state, state_nx;

    logic [BYTE_W-1:0] opcode_q;
    logic [IDX_W-1:0]  rcvd_q;
    logic              op_known;
    logic [IDX_W-1:0]  op_need;
    logic              proc_done;
    logic              q_empty, q_last;
    logic [BYTE_W-1:0] q_head;
    logic              q_push, q_pop;
    logic [BYTE_W-1:0] q_din;
    logic              wr_ok, rd_ok;
    logic              rqm, dio, busy;
    logic              go_exec;

    cmd_opcode_decode u_decode (
        .code    (opcode_q[4:0]),
        .known   (op_known),
        .nparams (op_need)
    );

    cmd_proc_timer #(.CYCLES(PROC_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_CMD_PROC),
        .done  (proc_done)
    );

    cmd_result_queue #(.DEPTH(RES_DEPTH), .W(BYTE_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (q_din),
        .pop   (q_pop),
        .head  (q_head),
        .empty (q_empty),
        .last  (q_last)
    );

    assign wr_ok   = host_wr && ((state == ST_CMD_IDLE) || (state == ST_CMD_PARAM));
    assign rd_ok   = host_rd && (state == ST_RESULT) && !q_empty;
    assign go_exec = (state == ST_CMD_PROC) && proc_done && op_known && (rcvd_q == op_need);
    assign q_pop   = rd_ok;

    always_comb begin
        q_push = 1'b0;
        q_din  = res_byte;
        if (state == ST_EXEC && res_push) begin
            q_push = 1'b1;
        end else if (state == ST_CMD_PROC && proc_done && !op_known) begin
            q_push = 1'b1;
            q_din  = INVALID_STATUS;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CMD_IDLE:  if (wr_ok) state_nx = ST_CMD_PROC;
            ST_CMD_PARAM: if (wr_ok) state_nx = ST_CMD_PROC;
            ST_CMD_PROC: begin
                if (proc_done) begin
                    if (!op_known)              state_nx = ST_RESULT;
                    else if (rcvd_q == op_need) state_nx = ST_EXEC;
                    else                        state_nx = ST_CMD_PARAM;
                end
            end
            ST_EXEC:      if (exec_done) state_nx = q_empty ? ST_CMD_IDLE : ST_RESULT;
            ST_RESULT:    if (q_empty || (rd_ok && q_last)) state_nx = ST_CMD_IDLE;
            default:      state_nx = ST_CMD_IDLE;
        endcase
    end

    // State register and command bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_CMD_IDLE;
            opcode_q    <= '0;
            rcvd_q      <= '0;
            param_valid <= 1'b0;
            param_idx   <= '0;
            param_byte  <= '0;
            exec_start  <= 1'b0;
        end else begin
            state       <= state_nx;
            param_valid <= 1'b0;
            exec_start  <= go_exec;
            if (wr_ok && state == ST_CMD_IDLE) begin
                opcode_q <= host_wdata;
                rcvd_q   <= '0;
            end
            if (wr_ok && state == ST_CMD_PARAM) begin
                param_valid <= 1'b1;
                param_idx   <= rcvd_q;
                param_byte  <= host_wdata;
                rcvd_q      <= rcvd_q + 1'b1;
            end
        end
    end

    // Output decode from state
    always_comb begin
        rqm        = 1'b0;
        dio        = 1'b0;
        busy       = 1'b1;
        fifo_en    = 1'b0;
        host_rdata = '0;
        unique case (state)
            ST_CMD_IDLE: begin
                rqm  = 1'b1;
                busy = 1'b0;
            end
            ST_CMD_PARAM: rqm = 1'b1;
            ST_CMD_PROC:  rqm = 1'b0;
            ST_EXEC:      fifo_en = 1'b1;
            ST_RESULT: begin
                dio        = 1'b1;
                rqm        = !q_empty;
                host_rdata = q_head;
            end
            default: busy = 1'b0;
        endcase
        msr = {rqm, dio, 1'b0, busy, 4'b0000};
    end

    assign exec_op = opcode_q;

endmodule

// File: rtl/disk_cmd_intake_chk.sv
module disk_cmd_intake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic [7:0] msr,
    input logic       fifo_en,
    input logic       param_valid,
    input logic       exec_start
);
    // R3
    rqm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && msr[7] && !msr[6]) |=> (!msr[7] ##1 !msr[7]));

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);

    // R6
    exec_rqm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> (!msr[7] && msr[4]));

    // R7
    fifo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr[7] || msr[6]) |-> !fifo_en);

    // R5
    param_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        param_valid |-> (msr[4] && !msr[7] && !msr[6]));

    // R6
    start_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> fifo_en);
endmodule

bind disk_cmd_intake disk_cmd_intake_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .msr         (msr),
    .fifo_en     (fifo_en),
    .param_valid (param_valid),
    .exec_start  (exec_start)
);

// File: tb/test_disk_cmd_intake.sv
module test_disk_cmd_intake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, msr, param_byte, exec_op;
    logic [3:0] param_idx;
    logic       fifo_en, param_valid, exec_start;
    logic       exec_done = 1'b0, res_push = 1'b0;
    logic [7:0] res_byte = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    disk_cmd_intake i_disk_cmd_intake (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .msr(msr),
        .fifo_en(fifo_en), .param_valid(param_valid), .param_idx(param_idx),
        .param_byte(param_byte), .exec_start(exec_start), .exec_op(exec_op),
        .exec_done(exec_done), .res_push(res_push), .res_byte(res_byte)
    );

    // opcode, expected parameter count (FF = invalid)
    localparam logic [15:0] VEC [10] = '{
        16'h0608, 16'hE608, 16'h4508, 16'h0F02, 16'h0302,
        16'h0401, 16'h0701, 16'h0800, 16'h1FFF, 16'h00FF
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] op, n, a, b;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 msr", msr, 8'h80);
        chk("R1 fifo_en", fifo_en, 0);
        chk("R1 exec_start", exec_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 msr after release", msr, 8'h80);
        chk("R1 rdata", host_rdata, 0);

        for (int v = 0; v < 10; v++) begin
            op = VEC[v][15:8];
            n  = VEC[v][7:0];
            a  = op ^ 8'h5A;
            b  = 8'hC0 + 8'(v);
            wr(op);
            chk("R3 rqm low 1", msr[7], 0);
            chk("R7 fifo off in command", fifo_en, 0);
            @(negedge clk);
            chk("R3 rqm low 2", msr[7], 0);
            @(negedge clk);
            if (n == 8'hFF) begin
                chk("R8 status", msr, 8'hD0);
                chk("R8 byte", host_rdata, 8'h80);
                chk("R8 no start", exec_start, 0);
                chk("R7 fifo off in result", fifo_en, 0);
                rd();
                chk("R8 back to command", msr, 8'h80);
                continue;
            end
            for (int k = 0; k < int'(n); k++) begin
                chk("R3 param request", msr, 8'h90);
                chk("R4 no early start", exec_start, 0);
                wr(op + 8'(k));
                chk("R5 valid", param_valid, 1);
                chk("R5 idx", param_idx, k);
                chk("R5 byte", param_byte, op + 8'(k));
                @(negedge clk);
                chk("R5 single pulse", param_valid, 0);
                @(negedge clk);
            end
            chk("R4 R6 start", exec_start, 1);
            chk("R6 op", exec_op, op);
            chk("R6 status", msr, 8'h10);
            chk("R6 fifo on", fifo_en, 1);
            res_push = 1'b1; res_byte = a;
            @(negedge clk);
            chk("R6 start one cycle", exec_start, 0);
            res_byte = b;
            @(negedge clk);
            res_push = 1'b0; exec_done = 1'b1;
            @(negedge clk);
            exec_done = 1'b0;
            chk("R9 status", msr, 8'hD0);
            chk("R9 first byte", host_rdata, a);
            chk("R7 fifo off in result", fifo_en, 0);
            rd();
            chk("R9 second byte", host_rdata, b);
            chk("R9 still ready", msr, 8'hD0);
            rd();
            chk("R9 back to command", msr, 8'h80);
        end

        // R10: stray read and push in command phase
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R10 read ignored", msr, 8'h80);
        chk("R10 rdata zero", host_rdata, 0);
        res_push = 1'b1; res_byte = 8'h33;
        @(negedge clk);
        res_push = 1'b0;

        // R2: write during RQM low is dropped
        wr(8'h04);
        wr(8'hEE);
        chk("R2 dropped write no pulse", param_valid, 0);
        @(negedge clk);
        chk("R2 param request", msr, 8'h90);
        wr(8'h11);
        chk("R2 idx after drop", param_idx, 0);
        chk("R2 byte after drop", param_byte, 8'h11);
        @(negedge clk);
        @(negedge clk);
        chk("R2 start after one param", exec_start, 1);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        chk("R10 R9 empty queue to command", msr, 8'h80);

        // R4: modifier bits on zero-parameter opcode
        wr(8'hA8);
        @(negedge clk);
        @(negedge clk);
        chk("R4 modifier zero-param start", exec_start, 1);
        chk("R4 modifier op", exec_op, 8'hA8);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        chk("R9 empty to command", msr, 8'h80);

        summary();
    end
endmodule